// File: doc/BRIEF.md
# Region-Relative Defective Pixel Classifier

This block grades a raster stream of sensor pixels against a reference level that belongs to the region of interest (210 by 210 active pixels) holding each pixel. The reference is computed elsewhere, for example as a region median, and arrives on an input alongside every pixel. Each pixel also carries its row, its column, an active-area flag and the test kind. The test kind is either a dark-field test, where pixels that sit too far above the reference are flagged, or a bright-field test, where pixels that stray outside a symmetric percentage window are flagged. The offsets and the percentage come from threshold inputs that a register bank elsewhere holds.

Beyond per-pixel grading, the block follows runs of major defects. A short horizontal run inside one row is reported as a cluster when it ends. A long vertical run down one column is reported as a column defect when it gets long enough. Four saturating counters accumulate major, minor, cluster and column findings over a frame, and a frame-start input clears them.

Top module: `pixel_defect_grader`

## Requirements
- R1: Dark-field test (test_bright_i = 0): a tested pixel with pix_i >= ref_i + dark_major_i raises major_o in the cycle after the pixel is presented.
- R2: Dark-field test: a tested pixel with pix_i >= ref_i + dark_minor_i that is not major raises minor_o (and not major_o) one cycle later. major_o and minor_o are never high together.
- R3: Bright-field test (test_bright_i = 1): with margin m = (ref_i * bright_pct_i + 50) / 100 in integer arithmetic, a tested pixel with pix_i >= ref_i + m, or with m <= ref_i and pix_i <= ref_i - m, raises major_o one cycle later. Both limits are inclusive. minor_o stays low in this test.
- R4: A pixel is tested only when pix_valid_i and pix_active_i are both high. An untested pixel raises no flag and changes no counter. A valid but inactive pixel ends any horizontal or vertical run.
- R5: A horizontal run is a sequence of major pixels in one row at columns c, c+1, c+2 and so on, presented back to back as valid pixels. When a run ends, cluster_o pulses for one cycle, in the cycle after the valid pixel that ends it, if the run length is between 2 and CLUSTER_MAX (20) inclusive. The run ends with a non-major pixel, a change of row or a column gap. Runs of length 1, or longer than CLUSTER_MAX, produce no pulse.
- R6: Each column keeps a count of consecutive major pixels. column_o pulses once, one cycle after the major pixel that brings a column's run to COL_MIN (21). It does not pulse again while that run continues. A valid non-major pixel in the column restarts the run.
- R7: cnt_major_o, cnt_minor_o, cnt_cluster_o and cnt_column_o each add one per matching event. They hold at 2^CNT_W - 1 rather than wrapping.
- R8: frame_start_i clears all four counters and all run state. A pixel presented in the same cycle is treated as the first pixel of the new frame: it is graded and counted, and it starts fresh runs.
- R9: After reset, all flags, events and counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Clears counters and run state |
| pix_valid_i | input | 1 | A pixel is present this cycle |
| pix_active_i | input | 1 | Pixel lies in the active area |
| test_bright_i | input | 1 | 0 dark-field test, 1 bright-field test |
| pix_i | input | PIX_W | Pixel level |
| ref_i | input | PIX_W | Reference level of the pixel's region |
| row_i | input | ROW_W | Row index |
| col_i | input | COL_W | Column index |
| dark_major_i | input | PIX_W | Dark major offset |
| dark_minor_i | input | PIX_W | Dark minor offset |
| bright_pct_i | input | PCT_W | Bright window percentage |
| major_o | output | 1 | Major defect flag |
| minor_o | output | 1 | Minor defect flag |
| cluster_o | output | 1 | Cluster defect event |
| column_o | output | 1 | Column defect event |
| cnt_major_o | output | CNT_W | Major defect count |
| cnt_minor_o | output | CNT_W | Minor defect count |
| cnt_cluster_o | output | CNT_W | Cluster count |
| cnt_column_o | output | CNT_W | Column defect count |

## Verification
Frame start and a graded pixel can arrive in the same cycle, and the block then has to clear and count at once. The bench raises frame_start_i together with a dark major pixel, after counters already hold earlier findings. It expects cnt_major_o to read exactly 1 afterwards, not 0 and not the old total plus one. A cluster end and a new major pixel also meet in one cycle when a run is broken by a row change. The bench expects the cluster pulse after that pixel, and it expects that pixel to start a new run.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
   typedef enum logic {TEST_DARK = 1'b0, TEST_BRIGHT = 1'b1} test_kind_e;
   localparam int unsigned PCT_DIV  = 100;
   localparam int unsigned PCT_HALF = 50;
endpackage

// File: rtl/pdg_grade.sv
module pdg_grade #(
   parameter int PIX_W = 12,
   parameter int PCT_W = 7
) (
   input  logic             bright_i,
   input  logic [PIX_W-1:0] pix_i,
   input  logic [PIX_W-1:0] ref_i,
   input  logic [PIX_W-1:0] dmaj_i,
   input  logic [PIX_W-1:0] dmin_i,
   input  logic [PCT_W-1:0] pct_i,
   output logic             major_o,
   output logic             minor_o
);
   import pdg_pkg::*;
   localparam int WW = PIX_W + PCT_W + 2;

   logic [WW-1:0] ref_w, pix_w, prod, margin, hi_lim, dmaj_lim, dmin_lim;
   logic          lo_hit, hi_hit;

   always_comb begin
      ref_w    = WW'(ref_i);
      pix_w    = WW'(pix_i);
      prod     = ref_w * WW'(pct_i) + WW'(PCT_HALF);
      margin   = prod / WW'(PCT_DIV);
      hi_lim   = ref_w + margin;
      hi_hit   = pix_w >= hi_lim;
      lo_hit   = (margin <= ref_w) && (pix_w <= (ref_w - margin));
      dmaj_lim = ref_w + WW'(dmaj_i);
      dmin_lim = ref_w + WW'(dmin_i);
      if (test_kind_e'(bright_i) == TEST_BRIGHT) begin
         major_o = hi_hit || lo_hit;
         minor_o = 1'b0;
      end else begin
         major_o = pix_w >= dmaj_lim;
         minor_o = !(pix_w >= dmaj_lim) && (pix_w >= dmin_lim);
      end
   end
endmodule

// File: rtl/pdg_hrun.sv
module pdg_hrun #(
   parameter int ROW_W       = 12,
   parameter int COL_W       = 12,
   parameter int CLUSTER_MAX = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             vld_i,
   input  logic             maj_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   output logic             fire_o,
   output logic             evt_o
);
   localparam int RUN_W = $clog2(CLUSTER_MAX + 2);
   localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(CLUSTER_MAX + 1);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(CLUSTER_MAX);

   logic [RUN_W-1:0] len_q, len_prev, len_nxt;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             have_q, contig, ends;

   if (CLUSTER_MAX < 2) begin : g_bad_max
      $error("CLUSTER_MAX must be at least 2");
   end

   always_comb begin
      len_prev = clr_i ? '0 : len_q;
      contig   = !clr_i && have_q && (row_i == row_q) && (col_i == col_q + COL_W'(1));
      ends     = (len_prev != '0) && !(maj_i && contig);
      fire_o   = vld_i && ends && (len_prev >= RUN_W'(2)) && (len_prev <= RUN_MAX);
      if (!maj_i)                       len_nxt = '0;
      else if (contig && len_prev != '0) len_nxt = (len_prev == RUN_CAP) ? RUN_CAP : len_prev + RUN_W'(1);
      else                              len_nxt = RUN_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         row_q  <= '0;
         col_q  <= '0;
         have_q <= 1'b0;
         evt_o  <= 1'b0;
      end else begin
         evt_o <= fire_o;
         if (vld_i) begin
            len_q  <= len_nxt;
            row_q  <= row_i;
            col_q  <= col_i;
            have_q <= 1'b1;
         end else if (clr_i) begin
            len_q  <= '0;
            have_q <= 1'b0;
         end
      end
   end

   // R5
   idle_no_cluster_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> !evt_o);
   // R5
   run_capped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= RUN_CAP);
endmodule

// File: rtl/pdg_vrun.sv
module pdg_vrun #(
   parameter int COLS    = 1024,
   parameter int COL_W   = 12,
   parameter int COL_MIN = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             vld_i,
   input  logic             maj_i,
   input  logic [COL_W-1:0] col_i,
   output logic             fire_o,
   output logic             evt_o
);
   localparam int IW    = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int CNT_W = $clog2(COL_MIN + 2);
   localparam logic [CNT_W-1:0] HIT = CNT_W'(COL_MIN);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(COL_MIN + 1);

   if (COLS > (1 << COL_W)) begin : g_bad_cols
      $error("COLS does not fit in COL_W");
   end
   if (COL_MIN < 2) begin : g_bad_min
      $error("COL_MIN must be at least 2");
   end

   logic [CNT_W-1:0] run_q [COLS];
   logic [CNT_W-1:0] cur, nxt;
   logic [IW-1:0]    idx;

   always_comb begin
      idx    = col_i[IW-1:0];
      cur    = clr_i ? '0 : run_q[idx];
      if (!maj_i)          nxt = '0;
      else if (cur >= HIT) nxt = CAP;
      else                 nxt = cur + CNT_W'(1);
      fire_o = vld_i && maj_i && (nxt == HIT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < COLS; i++) run_q[i] <= '0;
         evt_o <= 1'b0;
      end else begin
         evt_o <= fire_o;
         if (clr_i) begin
            for (int i = 0; i < COLS; i++) run_q[i] <= '0;
         end
         if (vld_i) run_q[idx] <= nxt;
      end
   end

   // R6
   col_needs_major_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(vld_i && maj_i) |=> !evt_o);
endmodule

// File: rtl/pdg_satcnt.sv
module pdg_satcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_o <= '0;
      else if (clr_i)       cnt_o <= inc_i ? W'(1) : '0;
      else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + W'(1);
   end

   // R7
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == TOP && !clr_i) |=> cnt_o == TOP);
   // R7
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/pixel_defect_grader.sv
module pixel_defect_grader #(
   parameter int PIX_W       = 12,
   parameter int PCT_W       = 7,
   parameter int ROW_W       = 12,
   parameter int COL_W       = 12,
   parameter int COLS        = 1024,
   parameter int CLUSTER_MAX = 20,
   parameter int COL_MIN     = 21,
   parameter int CNT_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start_i,
   input  logic             pix_valid_i,
   input  logic             pix_active_i,
   input  logic             test_bright_i,
   input  logic [PIX_W-1:0] pix_i,
   input  logic [PIX_W-1:0] ref_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [PIX_W-1:0] dark_major_i,
   input  logic [PIX_W-1:0] dark_minor_i,
   input  logic [PCT_W-1:0] bright_pct_i,
   output logic             major_o,
   output logic             minor_o,
   output logic             cluster_o,
   output logic             column_o,
   output logic [CNT_W-1:0] cnt_major_o,
   output logic [CNT_W-1:0] cnt_minor_o,
   output logic [CNT_W-1:0] cnt_cluster_o,
   output logic [CNT_W-1:0] cnt_column_o
);
   localparam int NCNT = 4;

   if (CNT_W < 1 || PIX_W < 2) begin : g_bad_w
      $error("width parameters out of range");
   end

   logic g_maj, g_min, tested, t_maj, t_min, h_fire, v_fire;
   logic [NCNT-1:0]  inc;
   logic [CNT_W-1:0] cnt [NCNT];

   pdg_grade #(.PIX_W(PIX_W), .PCT_W(PCT_W)) u_grade (
      .bright_i(test_bright_i), .pix_i(pix_i), .ref_i(ref_i),
      .dmaj_i(dark_major_i), .dmin_i(dark_minor_i), .pct_i(bright_pct_i),
      .major_o(g_maj), .minor_o(g_min));

   assign tested = pix_valid_i && pix_active_i;
   assign t_maj  = tested && g_maj;
   assign t_min  = tested && g_min;

   pdg_hrun #(.ROW_W(ROW_W), .COL_W(COL_W), .CLUSTER_MAX(CLUSTER_MAX)) u_hrun (
      .clk(clk), .rst_n(rst_n), .clr_i(frame_start_i), .vld_i(pix_valid_i),
      .maj_i(t_maj), .row_i(row_i), .col_i(col_i), .fire_o(h_fire), .evt_o(cluster_o));

   pdg_vrun #(.COLS(COLS), .COL_W(COL_W), .COL_MIN(COL_MIN)) u_vrun (
      .clk(clk), .rst_n(rst_n), .clr_i(frame_start_i), .vld_i(pix_valid_i),
      .maj_i(t_maj), .col_i(col_i), .fire_o(v_fire), .evt_o(column_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         major_o <= 1'b0;
         minor_o <= 1'b0;
      end else begin
         major_o <= t_maj;
         minor_o <= t_min;
      end
   end

   assign inc = {v_fire, h_fire, t_min, t_maj};

   for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      pdg_satcnt #(.W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr_i(frame_start_i),
         .inc_i(inc[k]), .cnt_o(cnt[k]));
   end

   assign cnt_major_o   = cnt[0];
   assign cnt_minor_o   = cnt[1];
   assign cnt_cluster_o = cnt[2];
   assign cnt_column_o  = cnt[3];

   // R2
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(major_o && minor_o));
   // R4
   untested_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_valid_i && pix_active_i) |=> !major_o && !minor_o);
   // R3
   bright_no_minor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_bright_i |=> !minor_o);
   // R6
   column_with_major_chk: assert property (@(posedge clk) disable iff (!rst_n)
      column_o |-> major_o);
endmodule

// File: tb/pixel_defect_grader_tb.sv
module pixel_defect_grader_tb_top;
   localparam int CW = 4;
   logic clk = 1'b0, rst_n = 1'b0;
   logic fs = 0, vld = 0, act = 0, br = 0;
   logic [11:0] pix = 0, rf = 0, row = 0, col = 0;
   logic major, minor, clus, colev;
   logic [CW-1:0] c_maj, c_min, c_clu, c_col;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pixel_defect_grader #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start_i(fs), .pix_valid_i(vld),
      .pix_active_i(act), .test_bright_i(br), .pix_i(pix), .ref_i(rf),
      .row_i(row), .col_i(col), .dark_major_i(12'd200), .dark_minor_i(12'd30),
      .bright_pct_i(7'd15), .major_o(major), .minor_o(minor), .cluster_o(clus),
      .column_o(colev), .cnt_major_o(c_maj), .cnt_minor_o(c_min),
      .cnt_cluster_o(c_clu), .cnt_column_o(c_col));

   // {bright, ref, pix, major, minor}
   localparam int NV = 11;
   localparam logic [26:0] VEC [NV] = '{
      {1'b0, 12'd500, 12'd700, 1'b1, 1'b0},
      {1'b0, 12'd500, 12'd699, 1'b0, 1'b1},
      {1'b0, 12'd500, 12'd530, 1'b0, 1'b1},
      {1'b0, 12'd500, 12'd529, 1'b0, 1'b0},
      {1'b1, 12'd700, 12'd805, 1'b1, 1'b0},
      {1'b1, 12'd700, 12'd804, 1'b0, 1'b0},
      {1'b1, 12'd700, 12'd595, 1'b1, 1'b0},
      {1'b1, 12'd700, 12'd596, 1'b0, 1'b0},
      {1'b1, 12'd333, 12'd383, 1'b1, 1'b0},
      {1'b1, 12'd333, 12'd283, 1'b1, 1'b0},
      {1'b1, 12'd333, 12'd382, 1'b0, 1'b0}};

   task automatic chk(input string tag, input int act_v, input int exp_v);
      n_chk++;
      if (act_v != exp_v) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
      end
   endtask

   task automatic px(input logic f, input logic a, input logic b, input int r,
                     input int c, input int rv, input int pv);
      @(negedge clk);
      fs = f; vld = 1; act = a; br = b;
      row = 12'(r); col = 12'(c); rf = 12'(rv); pix = 12'(pv);
      @(posedge clk); #1;
      fs = 0; vld = 0;
   endtask

   task automatic fstart();
      @(negedge clk); fs = 1; vld = 0;
      @(posedge clk); #1; fs = 0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R9 reset state
      chk("R9 major", major, 0); chk("R9 minor", minor, 0);
      chk("R9 cluster", clus, 0); chk("R9 column", colev, 0);
      chk("R9 counts", c_maj + c_min + c_clu + c_col, 0);

      // R1 R2 R3 table walk
      for (int i = 0; i < NV; i++) begin
         px(0, 1, VEC[i][26], i, 2 * i, int'(VEC[i][25:14]), int'(VEC[i][13:2]));
         chk($sformatf("R1/R3 major vec %0d", i), major, int'(VEC[i][1]));
         chk($sformatf("R2/R3 minor vec %0d", i), minor, int'(VEC[i][0]));
      end
      chk("R7 major count", c_maj, 5);
      chk("R7 minor count", c_min, 2);
      chk("R5 no cluster from singles", c_clu, 0);

      // R4 inactive pixel ignored
      px(0, 0, 0, 40, 90, 100, 4000);
      chk("R4 inactive major", major, 0);
      chk("R4 inactive minor", minor, 0);
      chk("R4 count unchanged", c_maj, 5);

      // R8 frame start with same-cycle pixel
      px(1, 1, 0, 50, 95, 100, 400);
      chk("R8 first pixel graded", major, 1);
      chk("R8 major count restarts", c_maj, 1);
      chk("R8 minor count cleared", c_min, 0);

      // R5 clusters
      fstart();
      for (int c = 10; c <= 12; c++) px(0, 1, 0, 3, c, 100, 400);
      chk("R5 no cluster mid run", clus, 0);
      px(0, 1, 0, 3, 13, 100, 100);
      chk("R5 run of 3 reported", clus, 1);
      px(0, 1, 0, 4, 20, 100, 400);
      px(0, 1, 0, 4, 21, 100, 100);
      chk("R5 run of 1 silent", clus, 0);
      for (int c = 0; c < 20; c++) px(0, 1, 0, 6, c, 100, 400);
      px(0, 1, 0, 6, 20, 100, 100);
      chk("R5 run of 20 reported", clus, 1);
      for (int c = 0; c < 21; c++) px(0, 1, 0, 7, c, 100, 400);
      px(0, 1, 0, 7, 21, 100, 100);
      chk("R5 run of 21 silent", clus, 0);
      px(0, 1, 0, 8, 0, 100, 400);
      px(0, 1, 0, 8, 1, 100, 400);
      px(0, 1, 0, 9, 0, 100, 400);
      chk("R5 row change ends run", clus, 1);
      chk("R5 new run pixel graded", major, 1);
      px(0, 1, 0, 9, 5, 100, 100);
      chk("R5 cluster count", c_clu, 3);

      // R6 column defect
      fstart();
      for (int r = 0; r < 22; r++) begin
         px(0, 1, 0, r, 60, 100, 400);
         if (r == 19) chk("R6 no event at 20", colev, 0);
         if (r == 20) chk("R6 event at 21", colev, 1);
         if (r == 21) chk("R6 single event", colev, 0);
      end
      chk("R6 column count", c_col, 1);
      chk("R7 major saturates", c_maj, 15);

      // R7 saturation from a fresh frame
      fstart();
      for (int r = 0; r < 20; r++) px(0, 1, 0, 100 + r, 3 * r, 100, 400);
      chk("R7 saturated major count", c_maj, 15);
      chk("R6 no column from scattered", c_col, 0);

      done = 1;
      summary();
   end
endmodule